// File: doc/BRIEF.md
# Sensor Unlock Serial Sequencer

This block drives a single transmit-only serial line toward a sensor that will not accept configuration until it has seen an unlock preamble. When a start pulse arrives, it sends a fixed unlock byte a set number of times. Each transmission occupies one timed slot of fixed length. After the last slot it streams eight command bytes, taken from two 32-bit input words, with no gap between frames.

Every frame has one start bit, eight data bits, an even parity bit and two stop bits. The bit period comes from an internal divider of the system clock. The slot length is worked out at elaboration from the clock frequency and the requested interval in microseconds. At 50 MHz and 1000 us this gives 50000 cycles.

The whole block runs in one clock domain with a synchronous active-high reset. Software sees only the `busy_o` and `done_o` outputs.

Top module: `sens_unlock_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `tx_o` is 1 and both `busy_o` and `done_o` are 0.
- R2: A frame lasts 12 bit periods of BAUD_DIV = round(CLK_HZ/BAUD) cycles each. The bits are sent in this order: a 0 start bit, data bits 0 through 7, a parity bit that makes the count of ones among the data and parity bits even, and then two 1 stop bits.
- R3: A sequence begins with exactly UNLOCK_COUNT frames carrying UNLOCK_BYTE. The defaults are 10 frames of 0xD4.
- R4: Consecutive unlock frames begin exactly GAP_CYC = CLK_HZ*GAP_US/1000000 cycles apart, measured from start bit to start bit. Between frames the line stays at 1.
- R5: The first command frame starts GAP_CYC cycles after the start bit of the last unlock frame.
- R6: Command byte k, for k from 0 to 7, is bits [8k+7:8k] of the 64-bit word {cmd_hi_i, cmd_lo_i}. The bytes are sent in increasing k.
- R7: Each command frame after the first starts on the cycle right after the previous frame's last stop bit ends, so there are no idle bits between command frames.
- R8: A start pulse while `busy_o` is 1 has no effect on the running sequence.
- R9: A start accepted at clock edge E raises `busy_o` from edge E. At edge E + UNLOCK_COUNT*GAP_CYC + 8*12*BAUD_DIV, `busy_o` falls and `done_o` is 1 for exactly one cycle. The start bit of the first unlock frame is driven from edge E.
- R10: A synchronous reset asserted in the middle of a sequence returns the block to the idle state of R1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Starts a sequence when the block is idle |
| cmd_lo_i | input | 32 | Command bytes 0 to 3, byte 0 in bits 7:0 |
| cmd_hi_i | input | 32 | Command bytes 4 to 7, byte 4 in bits 7:0 |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | High while a sequence is running |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
Some properties are checked on every cycle by assertions:
- `done_o` lasts one cycle and is never high together with `busy_o`.
- The line stays high whenever the block is idle.
- A frame is loaded only when the serializer can take it, and the line goes low on the cycle after a load.
- The command phase is reached only after the full unlock count.

Other behaviour can only be shown by the bench's reference model, which compares the line level on every cycle of whole sequences:
- the actual bit values and parity;
- the exact slot spacing before and after the preamble;
- the byte order taken from the two words;
- back-to-back command timing;
- the starts that are ignored while busy;
- reset in the middle of a sequence.

// File: rtl/sunl_pkg.sv
package sunl_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_UNLOCK = 2'd1,
    SQ_CMD    = 2'd2
  } seq_state_t;

  localparam int FRAME_BITS = 12;

  // start bit in bit 0, then data LSB first, even parity, two stop bits
  function automatic logic [FRAME_BITS-1:0] make_frame(input logic [7:0] d);
    return {2'b11, ^d, d, 1'b0};
  endfunction

endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV = 434
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == LAST);

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import sunl_pkg::*;
#(
  parameter int DIV = 434
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] data,
  output logic       tx,
  output logic       busy,
  output logic       frame_end,
  output logic       ready
);
  localparam int LW = $clog2(FRAME_BITS);

  logic                  tick;
  logic [FRAME_BITS-1:0] frame;
  logic [FRAME_BITS-2:0] shreg;
  logic [LW-1:0]         left;

  baud_tick_gen #(.DIV(DIV)) u_baud (
    .clk (clk),
    .rst (rst),
    .clr (load),
    .tick(tick)
  );

  assign frame     = make_frame(data);
  assign frame_end = busy && tick && (left == '0);
  assign ready     = !busy || frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx    <= 1'b1;
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (load) begin
      tx    <= frame[0];
      shreg <= frame[FRAME_BITS-1:1];
      left  <= LW'(FRAME_BITS - 1);
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (left == '0) begin
        busy <= 1'b0;
        tx   <= 1'b1;
      end else begin
        tx    <= shreg[0];
        shreg <= {1'b1, shreg[FRAME_BITS-2:1]};
        left  <= left - 1'b1;
      end
    end
  end

  // R2
  load_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> ready);

  // R2
  start_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !tx);

endmodule

// File: rtl/sens_unlock_seq.sv
module sens_unlock_seq
  import sunl_pkg::*;
#(
  parameter int         CLK_HZ       = 50_000_000,
  parameter int         BAUD         = 115_200,
  parameter int         GAP_US       = 1000,
  parameter logic [7:0] UNLOCK_BYTE  = 8'hD4,
  parameter int         UNLOCK_COUNT = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic [31:0] cmd_lo_i,
  input  logic [31:0] cmd_hi_i,
  output logic        tx_o,
  output logic        busy_o,
  output logic        done_o
);
  localparam int     CMD_BYTES = 8;
  localparam int     BAUD_DIV  = (CLK_HZ + BAUD / 2) / BAUD;
  localparam longint GAP_L     = (64'(CLK_HZ) * 64'(GAP_US)) / 64'd1000000;
  localparam int     GAP_CYC   = int'(GAP_L);
  localparam int     TW        = $clog2(GAP_CYC + 1);
  localparam int     UCW       = $clog2(UNLOCK_COUNT + 1);
  localparam int     IW        = $clog2(CMD_BYTES) + 1;
  localparam logic [TW-1:0]  GAP_LOAD = TW'(GAP_CYC - 1);
  localparam logic [UCW-1:0] UC_LAST  = UCW'(UNLOCK_COUNT);
  localparam logic [IW-1:0]  IDX_END  = IW'(CMD_BYTES);

  seq_state_t     state;
  logic [UCW-1:0] ucnt;
  logic [IW-1:0]  idx;
  logic           load;
  logic [7:0]     load_data;
  logic           slot_zero;
  logic           ser_tx, ser_busy, ser_end, ser_ready;
  logic [7:0]     cmd_byte [CMD_BYTES];
  logic [63:0]    cmd_word;

  assign cmd_word = {cmd_hi_i, cmd_lo_i};

  for (genvar g = 0; g < CMD_BYTES; g++) begin : g_split
    assign cmd_byte[g] = cmd_word[8*g +: 8];
  end

  always_comb begin
    load      = 1'b0;
    load_data = UNLOCK_BYTE;
    case (state)
      SQ_IDLE: begin
        load = start_i;
      end
      SQ_UNLOCK: begin
        if (slot_zero) begin
          load = 1'b1;
          if (ucnt == UC_LAST) load_data = cmd_byte[0];
        end
      end
      SQ_CMD: begin
        if (ser_end && (idx != IDX_END)) begin
          load      = 1'b1;
          load_data = cmd_byte[idx[IW-2:0]];
        end
      end
      default: load = 1'b0;
    endcase
  end

  interval_timer #(.W(TW)) u_slot (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_val(GAP_LOAD),
    .zero    (slot_zero)
  );

  frame_serializer #(.DIV(BAUD_DIV)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .data     (load_data),
    .tx       (ser_tx),
    .busy     (ser_busy),
    .frame_end(ser_end),
    .ready    (ser_ready)
  );

  assign tx_o = ser_tx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      ucnt   <= '0;
      idx    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start_i) begin
            state  <= SQ_UNLOCK;
            ucnt   <= UCW'(1);
            busy_o <= 1'b1;
          end
        end
        SQ_UNLOCK: begin
          if (slot_zero) begin
            if (ucnt == UC_LAST) begin
              state <= SQ_CMD;
              idx   <= IW'(1);
            end else begin
              ucnt <= ucnt + 1'b1;
            end
          end
        end
        SQ_CMD: begin
          if (ser_end) begin
            if (idx == IDX_END) begin
              state  <= SQ_IDLE;
              busy_o <= 1'b0;
              done_o <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (tx_o && !ser_busy));

  // R3
  unlock_before_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_CMD) |-> (ucnt == UC_LAST));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && state == SQ_UNLOCK && !slot_zero) |=> $stable(ucnt));

  // R4
  slot_covers_frame_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_UNLOCK && slot_zero) |-> ser_ready);

endmodule

// File: tb/tb_sens_unlock_seq.sv
`timescale 1ns/1ps
module tb_sens_unlock_seq;
  localparam int CLK_HZ = 1_000_000;
  localparam int BAUD   = 115_200;
  localparam int GAP_US = 1000;
  localparam int UC     = 10;
  localparam int DIV    = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int GAP    = CLK_HZ / 1000 * GAP_US / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [31:0] cmd_lo_i = '0;
  logic [31:0] cmd_hi_i = '0;
  logic tx_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  sens_unlock_seq #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .GAP_US(GAP_US),
    .UNLOCK_BYTE(8'hD4), .UNLOCK_COUNT(UC)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .cmd_lo_i(cmd_lo_i), .cmd_hi_i(cmd_hi_i),
    .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct {
    logic  tx;
    logic  busy;
    logic  done;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic push_one(input logic t, input logic b, input logic d, input string r);
    exp_t e;
    e.tx = t; e.busy = b; e.done = d; e.req = r;
    q.push_back(e);
  endtask

  // R2: start 0, data LSB first, even parity, two stop bits
  task automatic push_frame(input logic [7:0] v, input string r);
    logic [11:0] f;
    f = {2'b11, ^v, v, 1'b0};
    for (int i = 0; i < 12; i++)
      for (int k = 0; k < DIV; k++) push_one(f[i], 1'b1, 1'b0, r);
  endtask

  task automatic push_sequence(input logic [31:0] lo, input logic [31:0] hi);
    logic [63:0] w;
    w = {hi, lo};
    for (int u = 0; u < UC; u++) begin
      push_frame(8'hD4, "R2 R3");
      for (int k = 12 * DIV; k < GAP; k++)
        push_one(1'b1, 1'b1, 1'b0, (u == UC - 1) ? "R5" : "R4 R8");
    end
    for (int b = 0; b < 8; b++)
      push_frame(w[8*b +: 8], (b == 0) ? "R2 R6" : "R6 R7");
    push_one(1'b1, 1'b0, 1'b1, "R9");
  endtask

  task automatic compare(input string idle_req);
    exp_t e;
    if (q.size() != 0) e = q.pop_front();
    else begin
      e.tx = 1'b1; e.busy = 1'b0; e.done = 1'b0; e.req = idle_req;
    end
    checks++;
    if (tx_o !== e.tx || busy_o !== e.busy || done_o !== e.done) begin
      errors++;
      $display("FAIL %s cycle %0d: tx/busy/done actual %b%b%b expected %b%b%b",
               e.req, cyc, tx_o, busy_o, done_o, e.tx, e.busy, e.done);
    end
  endtask

  task automatic step(input logic s, input logic r, input string idle_req);
    @(negedge clk);
    cyc++;
    compare(idle_req);
    start_i = s;
    rst     = r;
    if (r) q.delete();
    else if (s && q.size() == 0) push_sequence(cmd_lo_i, cmd_hi_i);
  endtask

  task automatic run_to_end();
    while (q.size() != 0) step(1'b0, 1'b0, "R1");
    repeat (3) step(1'b0, 1'b0, "R1");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d, actual running expected finished", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) step(1'b0, 1'b1, "R1");
    repeat (4) step(1'b0, 1'b0, "R1");

    // mixed parity bytes
    cmd_lo_i = 32'h8001_7E03;
    cmd_hi_i = 32'hA5C3_0F10;
    step(1'b1, 1'b0, "R1");
    repeat (2500) step(1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, "R8");
    repeat (4000) step(1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, "R8");
    run_to_end();

    // all zeros / all ones bytes, start held high
    cmd_lo_i = 32'hFF00_FF00;
    cmd_hi_i = 32'h00FF_FF00;
    step(1'b1, 1'b0, "R1");
    repeat (10700) step(1'b1, 1'b0, "R8");
    step(1'b0, 1'b0, "R1");
    run_to_end();

    // R10: reset in the middle of a sequence
    cmd_lo_i = 32'h1234_5678;
    cmd_hi_i = 32'h9ABC_DEF0;
    step(1'b1, 1'b0, "R1");
    repeat (5003) step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, "R10");
    step(1'b0, 1'b0, "R10");
    repeat (5) step(1'b0, 1'b0, "R10");

    // fresh run after reset, reaches done
    step(1'b1, 1'b0, "R1");
    run_to_end();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule